// File: doc/BRIEF.md
# Multicarrier Level-Shifted Sine PWM Generator

This block drives the stepped-level switches of a single-phase nine-level inverter whose polarity is set by a separate full bridge. Because the bridge makes the negative half-wave, the modulator only has to deal with the magnitude of the sine reference. It builds `(LEVELS-1)/2` triangular carriers as digital up/down counters and stacks each one in its own slice of the reference range. Each carrier is compared with the rectified reference sample. Every comparison drives one gate output, and its inverse drives a second, complementary output.

A two-bit mode input sets how the carriers are arranged in phase and frequency. In-phase stacking, the upper and lower halves in opposition, alternating opposition and unequal carrier rates are all supported. A new mode is not applied when it is requested. It is applied at the clock edge that ends a period of the lowest carrier, and at that edge every carrier is resynchronised. A mode change therefore never cuts a carrier ramp short.

Top module: `ml_spwm_gen`

## Requirements
- R1: While `rst_n` is low, `gate_pos` and `gate_neg` are both all zero. After `rst_n` rises, both stay zero for two more clock edges. The third edge is the first one that loads comparison results.
- R2: Outside reset, `gate_neg` is the bitwise inverse of `gate_pos` in every cycle.
- R3: Carrier k spans the values `k*2^CAR_W` up to `(k+1)*2^CAR_W-1`. `gate_pos[k]` is high one cycle after `ref_mag` is greater than or equal to the carrier k value. With `ref_mag` at full scale all bits are high, and with `ref_mag` at zero bits 1 and above are low.
- R4: The ramp of each carrier starts at 0 after reset. It moves by one count per step, going up to `2^CAR_W-1` and back down to 0. A step occurs every `div` clocks, so one period is `2*(2^CAR_W-1)*div` clocks. In the in-phase, opposition and alternating modes `div` is `DIV_NOM`.
- R5: Mode code 0 (in-phase): every carrier uses its ramp value directly, and all carriers share the same timing.
- R6: Mode code 1 (opposition): carriers with index below `N_CAR/2` use the mirrored ramp `2^CAR_W-1-ramp`, and the upper carriers use the ramp directly.
- R7: Mode code 2 (alternating): odd-index carriers use the mirrored ramp, and even-index carriers use the ramp directly.
- R8: Mode code 3 (variable rate): no carrier is mirrored. Carrier 0 steps every `DIV_VF_A` clocks, carrier 1 every `DIV_VF_B` clocks, and the rest every `DIV_VF_C` clocks. All carriers complete whole periods within one carrier-0 period.
- R9: The active mode starts as code 0 after reset. It takes the value of `mode_sel` only at the edge that ends a carrier-0 period, and at that edge all carriers restart from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_sel | input | 2 | Requested carrier arrangement (0 in-phase, 1 opposition, 2 alternating, 3 variable rate) |
| ref_mag | input | REF_W | Rectified sine reference sample, unsigned, full scale `2^REF_W-1` |
| gate_pos | output | N_CAR | Comparison pulses, one per carrier |
| gate_neg | output | N_CAR | Complementary pulses, the inverse of `gate_pos` outside reset |

## Verification
The bench requests mode changes in the middle of a carrier period and expects the old arrangement to stay in force up to the exact carrier-0 boundary. A design that switches early, or that forgets to restart the faster carriers, shifts every following pulse edge. It drives the reference to zero and to full scale to test the `>=` decision at the band edges: a design with a strict comparison misses the full-scale case and the carrier-0 zero point. A reset issued mid-run checks that the complementary outputs fall low together with the true outputs rather than going high, and that the mode returns to in-phase. Pseudo-random references in each mode check the mirroring pattern and the separate carrier rates against an independent timing model.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    SPWM_PD   = 2'd0,
    SPWM_POD  = 2'd1,
    SPWM_APOD = 2'd2,
    SPWM_VF   = 2'd3
  } spwm_mode_e;
endpackage

// File: rtl/spwm_rst_sync.sv
module spwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sync_n = q2;
endmodule

// File: rtl/spwm_mode_hold.sv
module spwm_mode_hold
  import spwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bnd,
  input  logic [1:0] mode_req,
  output spwm_mode_e mode_act
);
  spwm_mode_e act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (bnd) act_d = spwm_mode_e'(mode_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= SPWM_PD;
    else        act_q <= act_d;
  end

  assign mode_act = act_q;
endmodule

// File: rtl/spwm_tri_carrier.sv
module spwm_tri_carrier #(
  parameter int CAR_W = 6,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic [CAR_W-1:0] ramp,
  output logic             wrap
);
  localparam logic [CAR_W-1:0] PEAK = {CAR_W{1'b1}};
  localparam logic [CAR_W-1:0] ONE  = CAR_W'(1);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [CAR_W-1:0] ramp_q, ramp_d;
  logic             up_q, up_d;
  logic             step_en;

  assign step_en = (pre_q == div - DIV_W'(1));
  assign wrap    = step_en && !up_q && (ramp_q == ONE);

  always_comb begin
    pre_d  = pre_q;
    ramp_d = ramp_q;
    up_d   = up_q;
    if (restart) begin
      pre_d  = '0;
      ramp_d = '0;
      up_d   = 1'b1;
    end else begin
      pre_d = step_en ? '0 : pre_q + DIV_W'(1);
      if (step_en) begin
        if (up_q) begin
          ramp_d = ramp_q + ONE;
          if (ramp_q == PEAK - ONE) up_d = 1'b0;
        end else begin
          ramp_d = ramp_q - ONE;
          if (ramp_q == ONE) up_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ramp_q <= '0;
      up_q   <= 1'b1;
    end else begin
      pre_q  <= pre_d;
      ramp_q <= ramp_d;
      up_q   <= up_d;
    end
  end

  assign ramp = ramp_q;
endmodule

// File: rtl/spwm_slicer.sv
module spwm_slicer #(
  parameter int N_CAR = 4,
  parameter int REF_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [REF_W-1:0]            ref_mag,
  input  logic [N_CAR-1:0][REF_W-1:0] car_val,
  output logic [N_CAR-1:0]            gate_pos,
  output logic [N_CAR-1:0]            gate_neg
);
  logic [N_CAR-1:0] hit;

  for (genvar k = 0; k < N_CAR; k++) begin : g_cmp
    assign hit[k] = (ref_mag >= car_val[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_pos <= '0;
      gate_neg <= '0;
    end else begin
      gate_pos <= hit;
      gate_neg <= ~hit;
    end
  end
endmodule

// File: rtl/ml_spwm_gen.sv
module ml_spwm_gen
  import spwm_pkg::*;
#(
  parameter  int LEVELS   = 9,
  parameter  int CAR_W    = 6,
  parameter  int DIV_NOM  = 4,
  parameter  int DIV_VF_A = 10,
  parameter  int DIV_VF_B = 5,
  parameter  int DIV_VF_C = 2,
  localparam int N_CAR    = (LEVELS - 1) / 2,
  localparam int SLOT_W   = $clog2(N_CAR),
  localparam int REF_W    = CAR_W + SLOT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [REF_W-1:0] ref_mag,
  output logic [N_CAR-1:0] gate_pos,
  output logic [N_CAR-1:0] gate_neg
);
  localparam int DIV_M1  = (DIV_NOM > DIV_VF_A) ? DIV_NOM : DIV_VF_A;
  localparam int DIV_M2  = (DIV_VF_B > DIV_VF_C) ? DIV_VF_B : DIV_VF_C;
  localparam int DIV_MAX = (DIV_M1 > DIV_M2) ? DIV_M1 : DIV_M2;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  logic                        run_n;
  logic                        bnd;
  spwm_mode_e                  mode_act;
  logic [N_CAR-1:0]            car_wrap;
  logic [N_CAR-1:0][CAR_W-1:0] car_ramp;
  logic [N_CAR-1:0][REF_W-1:0] car_val;

  spwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (run_n)
  );

  assign bnd = car_wrap[0];

  spwm_mode_hold u_mode (
    .clk      (clk),
    .rst_n    (run_n),
    .bnd      (bnd),
    .mode_req (mode_sel),
    .mode_act (mode_act)
  );

  for (genvar k = 0; k < N_CAR; k++) begin : g_car
    localparam int DIV_VF_K = (k == 0) ? DIV_VF_A : ((k == 1) ? DIV_VF_B : DIV_VF_C);
    localparam bit MIR_POD  = (k < N_CAR / 2);
    localparam bit MIR_APOD = (k % 2 == 1);

    logic [DIV_W-1:0] div_k;
    logic             mir_k;

    always_comb begin
      div_k = DIV_W'(DIV_NOM);
      mir_k = 1'b0;
      case (mode_act)
        SPWM_POD:  mir_k = MIR_POD;
        SPWM_APOD: mir_k = MIR_APOD;
        SPWM_VF:   div_k = DIV_W'(DIV_VF_K);
        default:   ;
      endcase
    end

    spwm_tri_carrier #(.CAR_W(CAR_W), .DIV_W(DIV_W)) u_tri (
      .clk     (clk),
      .rst_n   (run_n),
      .restart (bnd),
      .div     (div_k),
      .ramp    (car_ramp[k]),
      .wrap    (car_wrap[k])
    );

    assign car_val[k] = {SLOT_W'(k), (mir_k ? ~car_ramp[k] : car_ramp[k])};
  end

  spwm_slicer #(.N_CAR(N_CAR), .REF_W(REF_W)) u_slice (
    .clk      (clk),
    .rst_n    (run_n),
    .ref_mag  (ref_mag),
    .car_val  (car_val),
    .gate_pos (gate_pos),
    .gate_neg (gate_neg)
  );
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk #(
  parameter int N_CAR = 4,
  parameter int CAR_W = 6,
  parameter int REF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REF_W-1:0] ref_mag,
  input logic [N_CAR-1:0] gate_pos,
  input logic [N_CAR-1:0] gate_neg,
  input logic [1:0]       mode_act,
  input logic             bnd,
  input logic [N_CAR-1:0] car_wrap,
  input logic [CAR_W-1:0] ramp0
);
  localparam logic [REF_W-1:0] FULL = {REF_W{1'b1}};

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_low_r1: assert (gate_pos == '0 && gate_neg == '0)
        else $error("R1 outputs not low in reset");
    end
  end

  p_complement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_pos != '0 || gate_neg != '0) |-> (gate_neg == ~gate_pos))
    else $error("R2 complement broken");

  p_full_scale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_mag == FULL && (gate_pos != '0 || gate_neg != '0)) |=> (gate_pos == {N_CAR{1'b1}}))
    else $error("R3 full-scale reference not all high");

  p_zero_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_mag == '0) |=> (gate_pos[N_CAR-1:1] == '0))
    else $error("R3 zero reference drove an upper gate");

  p_ramp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ramp0) |-> (ramp0 == $past(ramp0) + CAR_W'(1) || ramp0 == $past(ramp0) - CAR_W'(1)))
    else $error("R4 carrier jumped");

  p_wrap_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |-> (car_wrap == {N_CAR{1'b1}}))
    else $error("R8 carriers not aligned at boundary");

  p_mode_bnd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_act) |-> $past(bnd))
    else $error("R9 mode changed off boundary");
endmodule

bind ml_spwm_gen spwm_chk #(.N_CAR(N_CAR), .CAR_W(CAR_W), .REF_W(REF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_mag  (ref_mag),
  .gate_pos (gate_pos),
  .gate_neg (gate_neg),
  .mode_act (mode_act),
  .bnd      (bnd),
  .car_wrap (car_wrap),
  .ramp0    (car_ramp[0])
);

// File: tb/tb_ml_spwm_gen.sv
module tb_ml_spwm_gen;
  localparam int CLK_P  = 10;
  localparam int CAR_W  = 6;
  localparam int N_CAR  = 4;
  localparam int REF_W  = 8;
  localparam int PEAK   = 63;
  localparam int DIV_N  = 4;
  localparam int DIV_A  = 10;
  localparam int DIV_B  = 5;
  localparam int DIV_C  = 2;

  logic             clk;
  logic             rst_n;
  logic [1:0]       mode_sel;
  logic [REF_W-1:0] ref_mag;
  logic [N_CAR-1:0] gate_pos;
  logic [N_CAR-1:0] gate_neg;

  ml_spwm_gen #(
    .LEVELS(9), .CAR_W(CAR_W), .DIV_NOM(DIV_N),
    .DIV_VF_A(DIV_A), .DIV_VF_B(DIV_B), .DIV_VF_C(DIV_C)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ref_mag(ref_mag), .gate_pos(gate_pos), .gate_neg(gate_neg)
  );

  typedef struct {
    int         idx;
    logic [3:0] pos;
    logic [3:0] neg;
    string      tag;
  } exp_t;

  exp_t        sb_q[$];
  int          ecount = 0;
  int          n_chk  = 0;
  int          n_fail = 0;
  int          hi_edges = 0;
  int          m_el = 0;
  int          cur_mode = 0;
  logic [31:0] lcg = 32'h1234_5678;
  bit          done = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) ecount <= ecount + 1;

  function automatic int div_of(int md, int k);
    if (md == 3) return (k == 0) ? DIV_A : ((k == 1) ? DIV_B : DIV_C);
    return DIV_N;
  endfunction

  function automatic bit mir_of(int md, int k);
    if (md == 1) return (k < N_CAR/2);
    if (md == 2) return (k % 2 == 1);
    return 1'b0;
  endfunction

  function automatic int ramp_at(int m, int d);
    int s;
    s = (m / d) % (2*PEAK);
    return (s <= PEAK) ? s : (2*PEAK - s);
  endfunction

  // driver side: model of the next edge, pushed to the scoreboard
  task automatic push_exp(string tag);
    exp_t it;
    it.idx = ecount + 1;
    it.tag = "R1";
    it.pos = '0;
    it.neg = '0;
    if (!rst_n) begin
      hi_edges = 0;
      m_el     = 0;
      cur_mode = 0;
    end else begin
      hi_edges++;
      if (hi_edges >= 3) begin
        for (int k = 0; k < N_CAR; k++) begin
          int r;
          int cv;
          r  = ramp_at(m_el, div_of(cur_mode, k));
          cv = k*(PEAK+1) + (mir_of(cur_mode, k) ? (PEAK - r) : r);
          it.pos[k] = (int'(ref_mag) >= cv);
        end
        it.neg = ~it.pos;
        it.tag = tag;
        if (m_el + 1 == 2*PEAK*div_of(cur_mode, 0)) begin
          m_el     = 0;
          cur_mode = int'(mode_sel);
        end else begin
          m_el++;
        end
      end
    end
    sb_q.push_back(it);
  endtask

  // pat 0: constant, 1: ramp, 2: pseudo-random
  task automatic run(int n, int pat, int cval, string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      case (pat)
        0: ref_mag = REF_W'(cval);
        1: ref_mag = REF_W'((c*7) % 256);
        default: begin
          lcg = lcg * 32'd1103515245 + 32'd12345;
          ref_mag = lcg[23:16];
        end
      endcase
      push_exp(tag);
    end
  endtask

  task automatic hold_reset(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      rst_n = 1'b0;
      push_exp("R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    push_exp("R1");
  endtask

  // monitor: compare what the design produced with the queued expectation
  always @(posedge clk) begin
    #(CLK_P/4);
    while (sb_q.size() > 0 && sb_q[0].idx <= ecount) begin
      exp_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (gate_pos !== it.pos) begin
        n_fail++;
        $display("FAIL %s edge %0d gate_pos actual=%b expected=%b", it.tag, it.idx, gate_pos, it.pos);
      end
      n_chk++;
      if (gate_neg !== it.neg) begin
        n_fail++;
        $display("FAIL %s edge %0d gate_neg actual=%b expected=%b",
                 (it.tag == "R1") ? "R1" : "R2", it.idx, gate_neg, it.neg);
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    mode_sel = 2'd0;
    ref_mag  = '0;
    hold_reset(5);                 // R1 reset state and release delay
    run(60, 0, 255, "R3");         // R3 full scale: all high
    run(60, 0, 0, "R3");           // R3 zero: only carrier 0 at its low point
    run(100, 0, 128, "R3");        // R3 band edge in the middle
    run(300, 1, 0, "R4");          // R4 ramp timing against a sweep
    run(600, 2, 0, "R5");          // R5 in-phase
    mode_sel = 2'd1;
    run(600, 2, 0, "R9");          // R9 switch waits for boundary
    run(1100, 2, 0, "R6");         // R6 opposition
    mode_sel = 2'd2;
    run(600, 2, 0, "R9");
    run(1100, 2, 0, "R7");         // R7 alternating
    mode_sel = 2'd3;
    run(600, 2, 0, "R9");
    run(2600, 2, 0, "R8");         // R8 variable rate
    run(40, 0, 255, "R3");
    mode_sel = 2'd0;
    run(1400, 2, 0, "R9");         // back to in-phase from mid-period request
    run(300, 2, 0, "R5");
    mode_sel = 2'd1;
    hold_reset(3);                 // R1 mid-run reset, R9 mode back to code 0
    run(700, 2, 0, "R9");
    run(600, 2, 0, "R6");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule